// File: doc/BRIEF.md
# Single-Slope PWM Waveform Generator

This block produces one pulse-width-modulated output from an 8-bit up-counter. The counter advances by one on every cycle in which an external prescaler raises the tick enable. It runs from 0 up to its top value of 255, then wraps back to 0, so one output period lasts 256 ticks. With a prescale factor N (for example 1, 8, 32, 64, 128, 256 or 1024) the output frequency is the clock frequency divided by N × 256.

Software writes a new compare value through a one-cycle write port. The value first lands in a holding buffer. It becomes the active compare value only at the end of a period, so a change of duty never cuts a period short. A two-bit mode input selects how the output reacts to the counter. In the PWM modes the output is set or cleared at the wrap and at the compare point. In toggle mode the output flips once per period and gives a 50% square wave. In the off mode the output is held low. A one-clock strobe reports each compare match.

Top module: `fastpwm_gen`

## Requirements
- R1: During and after a synchronous reset the count, the output, the match strobe, the buffered compare value and the active compare value are all 0.
- R2: On each clock with the tick enable high, the count rises by one and wraps from 255 to 0. The new count is visible from the next clock.
- R3: A write stores the data in the buffer only. The active compare value takes the buffer content held before the tick at which the count is 255. A write made in that same cycle becomes active one period later.
- R4: Mode 2'b10 is non-inverting. A tick at count 255 drives the output to 1. A tick at a count equal to the active compare value C, when the count is not 255, drives it to 0. Over a full period the output is high for C+1 ticks.
- R5: Mode 2'b11 is inverting. It follows R4 with the output levels swapped, so the output is high for 255−C ticks per period.
- R6: C = 0 gives a pulse one tick wide in each period: high in mode 2'b10, low in mode 2'b11. C = 255 gives a constant level: 1 in mode 2'b10, 0 in mode 2'b11.
- R7: Mode 2'b01 flips the output on each tick at which the count equals C. This gives a 50% square wave with a period of 512 ticks.
- R8: Mode 2'b00 drives the output low from the next clock, whatever the tick enable does.
- R9: The match strobe is high for exactly the one clock that follows a tick whose count equalled C. It is low in every other clock.
- R10: In a clock with the tick enable low, the count and the active compare value do not change. The output does not change either, except as R8 requires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Prescaled tick; counter and output advance only when high |
| mode | input | 2 | Output mode: 00 off, 01 toggle, 10 non-inverting, 11 inverting |
| cmp_wr_en | input | 1 | Write strobe for the compare buffer |
| cmp_wr_data | input | CNT_W | Compare value to buffer |
| wave_out | output | 1 | Waveform output |
| count_out | output | CNT_W | Current counter value |
| match_stb | output | 1 | One-clock strobe after a compare-match tick |

## Verification
A wrong active compare value shows up within a single period. The match strobe lands at the wrong count, and the high time measured in that period differs from C+1. A compare value loaded mid-period instead of at the top shows as a period whose duty belongs to neither the old value nor the new one. A counter or output register that moves without a tick is caught on the next clock, because the count or level changes while the tick enable is low. The bench sweeps the compare extremes and interior values in both PWM polarities. It also covers toggle mode, gated tick patterns and a write that coincides with the top count.

// File: rtl/fastpwm_gen_pkg.sv
package fastpwm_gen_pkg;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'b00,
        OUT_TOGGLE = 2'b01,
        OUT_CLEAR  = 2'b10,
        OUT_SET    = 2'b11
    } out_mode_e;

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic         at_top
);
    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.cnt = s_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt    = s_q.cnt;
    assign at_top = (s_q.cnt == TOP);
endmodule

// File: rtl/pwm_cmp_buf.sv
module pwm_cmp_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         at_top,
    input  logic [W-1:0] cnt,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] act,
    output logic         hit,
    output logic         stb
);
    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] act;
        logic         stb;
    } cmp_state_t;

    cmp_state_t s_d, s_q;

    assign hit = (cnt == s_q.act);

    always_comb begin
        s_d     = s_q;
        s_d.stb = tick && hit;
        if (wr_en) begin
            s_d.pend = wr_data;
        end
        // period boundary: buffered value takes over for the next period
        if (tick && at_top) begin
            s_d.act = s_q.pend;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act = s_q.act;
    assign stb = s_q.stb;
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
    import fastpwm_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] mode,
    input  logic       at_top,
    input  logic       hit,
    output logic       wave
);
    typedef struct packed {
        logic lvl;
    } wave_state_t;

    wave_state_t s_d, s_q;
    out_mode_e   m;

    assign m = out_mode_e'(mode);

    always_comb begin
        s_d = s_q;
        unique case (m)
            OUT_OFF:    s_d.lvl = 1'b0;
            OUT_TOGGLE: if (tick && hit) s_d.lvl = ~s_q.lvl;
            OUT_CLEAR: begin
                if (tick && at_top)   s_d.lvl = 1'b1;
                else if (tick && hit) s_d.lvl = 1'b0;
            end
            OUT_SET: begin
                if (tick && at_top)   s_d.lvl = 1'b0;
                else if (tick && hit) s_d.lvl = 1'b1;
            end
            default:    s_d.lvl = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wave = s_q.lvl;
endmodule

// File: rtl/fastpwm_gen.sv
module fastpwm_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic [1:0]       mode,
    input  logic             cmp_wr_en,
    input  logic [CNT_W-1:0] cmp_wr_data,
    output logic             wave_out,
    output logic [CNT_W-1:0] count_out,
    output logic             match_stb
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ocr_act;
    logic             at_top;
    logic             hit;

    pwm_counter #(.W(CNT_W)) i_counter (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_en),
        .cnt    (cnt),
        .at_top (at_top)
    );

    pwm_cmp_buf #(.W(CNT_W)) i_cmp (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_en),
        .at_top  (at_top),
        .cnt     (cnt),
        .wr_en   (cmp_wr_en),
        .wr_data (cmp_wr_data),
        .act     (ocr_act),
        .hit     (hit),
        .stb     (match_stb)
    );

    pwm_wave i_wave (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_en),
        .mode   (mode),
        .at_top (at_top),
        .hit    (hit),
        .wave   (wave_out)
    );

    assign count_out = cnt;
endmodule

// File: rtl/fastpwm_gen_chk.sv
module fastpwm_gen_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick_en,
    input logic [1:0]   mode,
    input logic [W-1:0] count_out,
    input logic [W-1:0] ocr_act,
    input logic         wave_out,
    input logic         match_stb
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] TOP = '1;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> (count_out - $past(count_out)) == ONE);

    assert_count_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(count_out));

    assert_wave_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && mode != 2'b00) |=> $stable(wave_out));

    assert_off_low_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |=> !wave_out);

    assert_strobe_cause_R9: assert property (@(posedge clk) disable iff (rst)
        match_stb |-> $past(tick_en));

    assert_act_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(tick_en && count_out == TOP) |=> $stable(ocr_act));
endmodule

bind fastpwm_gen fastpwm_gen_chk #(.W(CNT_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .mode      (mode),
    .count_out (count_out),
    .ocr_act   (ocr_act),
    .wave_out  (wave_out),
    .match_stb (match_stb)
);

// File: tb/test_fastpwm_gen.sv
module test_fastpwm_gen;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         tick_en;
    logic [1:0]   mode;
    logic         cmp_wr_en;
    logic [W-1:0] cmp_wr_data;
    logic         wave_out;
    logic [W-1:0] count_out;
    logic         match_stb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // bench reference state, derived from the requirements
    int m_cnt, m_ocr, m_buf, m_wave, m_stb;
    int hi_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    fastpwm_gen #(.CNT_W(W)) i_fastpwm_gen (
        .clk         (clk),
        .rst         (rst),
        .tick_en     (tick_en),
        .mode        (mode),
        .cmp_wr_en   (cmp_wr_en),
        .cmp_wr_data (cmp_wr_data),
        .wave_out    (wave_out),
        .count_out   (count_out),
        .match_stb   (match_stb)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic string wave_req(input logic [1:0] md);
        case (md)
            2'b00:   return "R8 off-low";
            2'b01:   return "R7 toggle";
            2'b10:   return "R4 non-inverting";
            default: return "R5 inverting";
        endcase
    endfunction

    // one clock: drive at negedge, predict, sample at next negedge
    task automatic cyc(input bit t, input logic [1:0] md, input bit we, input int wd);
        int n_cnt, n_ocr, n_wave;
        tick_en     = t;
        mode        = md;
        cmp_wr_en   = we;
        cmp_wr_data = W'(wd);
        n_cnt = m_cnt; n_ocr = m_ocr; n_wave = m_wave;
        m_stb = (t && m_cnt == m_ocr) ? 1 : 0;
        if (t) begin
            n_cnt = (m_cnt + 1) % 256;
            if (m_cnt == 255) n_ocr = m_buf;
        end
        if (md == 2'b00) n_wave = 0;
        else if (t) begin
            case (md)
                2'b01: if (m_cnt == m_ocr) n_wave = 1 - m_wave;
                2'b10: if (m_cnt == 255) n_wave = 1; else if (m_cnt == m_ocr) n_wave = 0;
                default: if (m_cnt == 255) n_wave = 0; else if (m_cnt == m_ocr) n_wave = 1;
            endcase
        end
        if (we) m_buf = wd;
        m_cnt = n_cnt; m_ocr = n_ocr; m_wave = n_wave;
        @(posedge clk);
        @(negedge clk);
        check(t ? "R2 count step" : "R10 count hold", int'(count_out), m_cnt);
        check(wave_req(md), int'(wave_out), m_wave);
        check("R9 match strobe", int'(match_stb), m_stb);
        if (wave_out) hi_cnt++;
    endtask

    task automatic run(input int n, input logic [1:0] md);
        for (int i = 0; i < n; i++) cyc(1'b1, md, 1'b0, 0);
    endtask

    task automatic to_top(input logic [1:0] md);
        while (m_cnt != 255) cyc(1'b1, md, 1'b0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int vals[7] = '{0, 1, 64, 127, 200, 254, 255};
        rst = 1'b1; tick_en = 1'b1; mode = 2'b10; cmp_wr_en = 1'b1; cmp_wr_data = '1;
        m_cnt = 0; m_ocr = 0; m_buf = 0; m_wave = 0; m_stb = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset count", int'(count_out), 0);
        check("R1 reset wave", int'(wave_out), 0);
        check("R1 reset strobe", int'(match_stb), 0);
        rst = 1'b0;
        // first period after reset runs on the reset compare value 0
        cyc(1'b1, 2'b10, 1'b0, 0);
        check("R1 buffer cleared: strobe at count 0", int'(match_stb), 1);

        // PWM duty sweep in both polarities (R4, R5, R6)
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 7; k++) begin
                logic [1:0] md;
                md = (p == 0) ? 2'b10 : 2'b11;
                cyc(1'b1, md, 1'b1, vals[k]);
                to_top(md);
                cyc(1'b1, md, 1'b0, 0);   // load tick
                hi_cnt = 0;
                run(255, md);
                to_top(md);
                cyc(1'b1, md, 1'b0, 0);
                hi_cnt = 0;
                run(256, md);
                if (p == 0) check("R4/R6 high ticks per period", hi_cnt, vals[k] + 1);
                else        check("R5/R6 high ticks per period", hi_cnt, 255 - vals[k]);
            end
        end

        // R3: write during the top tick becomes active only next period
        cyc(1'b1, 2'b10, 1'b1, 40);
        to_top(2'b10);
        cyc(1'b1, 2'b10, 1'b1, 90);       // load 40, buffer now 90
        hi_cnt = 0;
        run(256, 2'b10);
        check("R3 same-cycle write deferred", hi_cnt, 41);
        hi_cnt = 0;
        run(256, 2'b10);
        check("R3 write active after next top", hi_cnt, 91);

        // R7 toggle: 50% over 512 ticks
        cyc(1'b1, 2'b01, 1'b1, 100);
        to_top(2'b01);
        cyc(1'b1, 2'b01, 1'b0, 0);
        hi_cnt = 0;
        run(512, 2'b01);
        check("R7 toggle duty over 512 ticks", hi_cnt, 256);

        // R10 gated ticks in every active mode
        for (int md = 1; md < 4; md++) begin
            for (int i = 0; i < 900; i++) cyc(((i % 3) != 0), md[1:0], (i == 450), 17);
        end

        // R8 off mode with and without ticks
        for (int i = 0; i < 600; i++) cyc((i % 2) == 0, 2'b00, 1'b0, 0);
        check("R8 output low in off mode", int'(wave_out), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule